// File: doc/BRIEF.md
# External Interrupt Request Detector

This block turns two active-low external interrupt pins into pending-request flags for an interrupt controller. Each pin first passes through a clocked synchroniser. It is then examined only on cycles where the machine-cycle strobe is high. A per-channel mode bit selects how the pin is detected. In level mode the flag tracks the sampled pin. In edge mode the flag latches when a high sample is followed by a low sample.

The flags and mode bits form a four-bit control nibble. The interrupt controller pulses a per-channel acknowledge when it vectors to a handler, and this clears that channel's flag. Software can overwrite the whole nibble in one cycle to set the modes, or to set and clear flags directly.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset the control nibble `ctrl` reads 0 (both channels in level mode, no request pending).
- R2: `ctrl` bit 3 is the channel 1 flag, bit 2 the channel 1 mode, bit 1 the channel 0 flag and bit 0 the channel 0 mode. A cycle with `wr_en` high loads `wr_data` into all four bits at the next edge. The mode bits change only through such a write.
- R3: Pins are sampled only at clock edges where `mc_en` is high. A low pulse that starts and ends between two strobes leaves the flag unchanged.
- R4: With mode bit 1 (edge), a strobe whose sample is low, after a previous strobe whose sample was high, sets the flag to 1. The flag then stays 1 at later strobes whatever the pin does.
- R5: In edge mode, a pin held low after an acknowledge does not set the flag again until a new high-to-low transition is sampled.
- R6: With mode bit 0 (level), each strobe loads the flag with the inverse of the sampled pin: 1 when the pin samples low, 0 when it samples high.
- R7: In level mode, if the pin still samples low after an acknowledge, the next strobe sets the flag again.
- R8: A high bit in `ack` (bit 0 for channel 0, bit 1 for channel 1) clears only that channel's flag at the next edge.
- R9: In the same cycle, a hardware set beats an acknowledge, and a software write beats both.
- R10: A pin change is seen by a strobe no earlier than the third rising clock edge after the change. A strobe at the second edge still sees the old level.
- R11: The two channels are independent: the pin, mode and acknowledge of one channel never change the other channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_en | input | 1 | Machine-cycle strobe; pins are sampled when high |
| pin_n | input | 2 | Active-low external interrupt pins, asynchronous |
| ack | input | 2 | Per-channel acknowledge pulse from vectoring |
| wr_en | input | 1 | Software write strobe for the control nibble |
| wr_data | input | 4 | Value written to the control nibble |
| ctrl | output | 4 | Control nibble: {flag1, mode1, flag0, mode0} |

## Verification
The bench places a strobe on the second edge after a pin change. A design with one synchroniser stage too few would latch the request early. It drops the pin low and raises it again between two strobes, which catches a design that samples on every clock. After an acknowledge it holds the pin low. In edge mode a design that ignores the previous sample would fire again. In level mode a design that fails to re-arm would drop the request. It also puts acknowledge, strobe and write in the same cycle. A wrong priority would then lose a fresh request or overrule software.

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mc_en,
  input  logic [1:0] pin_n,
  input  logic [1:0] ack,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] ctrl
);
  localparam int NCH = 2;

  logic [SYNC_STAGES-1:0] sync_q [NCH];
  logic [NCH-1:0] smp, prev_q, flag_q, mode_q, edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) sync_q[i] <= '1;
    end else begin
      for (int i = 0; i < NCH; i++)
        sync_q[i] <= {sync_q[i][SYNC_STAGES-2:0], pin_n[i]};
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign smp[g]      = sync_q[g][SYNC_STAGES-1];
      assign edge_hit[g] = mc_en & mode_q[g] & prev_q[g] & ~smp[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else if (mc_en) prev_q <= smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      flag_q <= {wr_data[3], wr_data[1]};
      mode_q <= {wr_data[2], wr_data[0]};
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (mc_en && !mode_q[i]) flag_q[i] <= ~smp[i];
        else if (edge_hit[i])    flag_q[i] <= 1'b1;
        else if (ack[i])         flag_q[i] <= 1'b0;
      end
    end
  end

  assign ctrl = {flag_q[1], mode_q[1], flag_q[0], mode_q[0]};

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));

  // R3
  flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_en && !wr_en && ack == 2'b00) |=> $stable(flag_q));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctrl == $past(wr_data));

  generate
    for (g = 0; g < NCH; g++) begin : g_chk
      // R8
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[g] && !mc_en && !wr_en) |=> !flag_q[g]);
      // R5
      edge_norearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[g] && !prev_q[g] && !flag_q[g] && !wr_en) |=> !flag_q[g]);
    end
  endgenerate
endmodule

// File: tb/tb_ext_irq_detect.sv
module tb_ext_irq_detect;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_en = 1'b0;
  logic [1:0] pin_n = 2'b11;
  logic [1:0] ack = 2'b00;
  logic wr_en = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic [3:0] ctrl;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  ext_irq_detect dut (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .pin_n(pin_n),
    .ack(ack), .wr_en(wr_en), .wr_data(wr_data), .ctrl(ctrl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) tick();
  endtask

  task automatic strobe();
    mc_en = 1'b1; tick(); mc_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] d);
    wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
  endtask

  task automatic ack_pulse(input logic [1:0] m);
    ack = m; tick(); ack = 2'b00;
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  task automatic t_reset();
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 reset", ctrl, 4'b0000);
  endtask

  task automatic t_layout();
    wr(4'b1010);
    check("R2 flags written", ctrl, 4'b1010);
    wr(4'b0101);
    check("R2 modes written", ctrl, 4'b0101);
  endtask

  task automatic t_sync();
    settle(); strobe();
    pin_n[0] = 1'b0;
    tick();
    strobe();
    check("R10 second edge sees old level", ctrl, 4'b0101);
    settle(); strobe();
    check("R4 edge sets flag", ctrl, 4'b0111);
  endtask

  task automatic t_edge_hold();
    strobe();
    check("R4 held low keeps flag", ctrl, 4'b0111);
    pin_n[0] = 1'b1; settle(); strobe();
    check("R4 high again keeps flag", ctrl, 4'b0111);
    ack_pulse(2'b01);
    check("R8 ack clears ch0", ctrl, 4'b0101);
  endtask

  task automatic t_window();
    pin_n[0] = 1'b0;
    repeat (6) tick();
    check("R3 no strobe no flag", ctrl, 4'b0101);
    pin_n[0] = 1'b1; settle(); strobe();
    check("R3 pulse between strobes missed", ctrl, 4'b0101);
    pin_n[0] = 1'b0; settle(); strobe();
    check("R4 sampled fall sets flag", ctrl, 4'b0111);
  endtask

  task automatic t_norearm();
    ack_pulse(2'b01);
    strobe(); strobe();
    check("R5 held low no rearm", ctrl, 4'b0101);
  endtask

  task automatic t_level();
    wr(4'b0001);
    pin_n[1] = 1'b0; settle(); strobe();
    check("R6 level low sets flag", ctrl, 4'b1001);
    ack_pulse(2'b10);
    check("R8 ack clears ch1", ctrl, 4'b0001);
    strobe();
    check("R7 level rearms", ctrl, 4'b1001);
    pin_n[1] = 1'b1; settle(); strobe();
    check("R6 level high clears flag", ctrl, 4'b0001);
  endtask

  task automatic t_indep();
    pin_n[0] = 1'b1; settle(); strobe();
    pin_n = 2'b00; settle(); strobe();
    check("R11 both channels set", ctrl, 4'b1011);
    ack_pulse(2'b01);
    check("R11 ch1 untouched by ch0 ack", ctrl, 4'b1001);
  endtask

  task automatic t_priority();
    pin_n[0] = 1'b1; settle(); strobe();
    check("R11 ch1 level stays set", ctrl, 4'b1001);
    pin_n[0] = 1'b0; settle();
    mc_en = 1'b1; ack = 2'b11; tick(); mc_en = 1'b0; ack = 2'b00;
    check("R9 hardware set beats ack", ctrl, 4'b1011);
    mc_en = 1'b1; wr_en = 1'b1; wr_data = 4'b0100; ack = 2'b11;
    tick();
    mc_en = 1'b0; wr_en = 1'b0; ack = 2'b00;
    check("R9 write beats hardware", ctrl, 4'b0100);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_layout();
    t_sync();
    t_edge_hold();
    t_window();
    t_norearm();
    t_level();
    t_indep();
    t_priority();
    summary();
  end
endmodule